// File: doc/BRIEF.md
# Byte-Lane Asynchronous Memory Emulator

A clock-sampled, synthesizable stand-in for a 16-bit-wide asynchronous static memory. Its controls are active low: chip select, write strobe, output enable, and one select for each byte lane. The block reads these controls and produces the read, write, deselect and output-disabled behaviour for each byte lane separately. Writes are byte-masked and happen on the rising clock edge when the controls call for a write. Read data comes straight from the array without a register. The bidirectional data bus is split into an input word, an output word and a two-bit lane drive vector. A driven bit in the lane vector means the matching byte is on the bus. A clear bit means that byte floats.

Two protection features keep the array from being corrupted. The first is a supply-low input: while it is high, no write can happen. The second is a lockout window counted in clock cycles. It starts after reset and again each time the supply-low input falls, and writes stay blocked until it runs out. Reset clears only the lockout state. The array keeps its contents through reset, as nonvolatile storage would.

The full device holds 65,536 words, which is an address width of 16. The parameter default is a smaller array so that elaboration stays light.

Top module: `byte_lane_mem`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits. A full-word write to any address, including 0 and the top address, reads back unchanged at that address.
- R2: While ce_n is high, dq_oe is 2'b00 whatever the other inputs are.
- R3: A read happens when ce_n=0, we_n=1 and oe_n=0. In that case dq_oe[0] equals !lb_n, dq_oe[1] equals !ub_n, and dout[7:0] and dout[15:8] carry the lower and upper bytes of the word at addr.
- R4: In read mode (ce_n=0, we_n=1), dq_oe is 2'b00 when oe_n is high or when lb_n and ub_n are both high.
- R5: A write happens when ce_n=0 and we_n=0, and oe_n has no effect. At the clock edge, din[7:0] is stored if lb_n=0 and din[15:8] is stored if ub_n=0. A lane whose select is high keeps its old byte. dq_oe is 2'b00 during the write.
- R6: No write happens unless ce_n and we_n are both low. In particular, we_n low with ce_n high leaves the array unchanged.
- R7: While vdd_low is high, no write happens for any input combination.
- R8: After rst_n is released, the first LOCK_CYCLES rising edges perform no write. A write request at edge LOCK_CYCLES+1 is accepted.
- R9: A rising edge that samples vdd_low high restarts the lockout. The next LOCK_CYCLES edges perform no write, and the edge after them can write.
- R10: Array contents are unchanged by asserting and releasing rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the lockout state |
| vdd_low | input | 1 | High while the supply is below the write-inhibit level |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte select, active low |
| ub_n | input | 1 | Upper byte select, active low |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data at addr |
| dq_oe | output | 2 | Lane drive: bit 0 lower byte, bit 1 upper byte |

## Verification
The assertions assume that the controls are synchronous to clk and stable around each rising edge. They also assume the array has been written before a value is compared, because its contents are never reset. The bench drives every input on the falling edge and samples just after it, so each write lands on exactly one known rising edge. The bench also writes each address it later compares before it makes that comparison. The lockout checks hold a write request across exactly LOCK_CYCLES edges and then look at the result through an ordinary read.

// File: rtl/byte_lane_mem.sv
module byte_lane_mem #(
  parameter int ADDR_W      = 10,
  parameter int LOCK_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vdd_low,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        dq_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = 2;
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [15:0]      mem [DEPTH];
  logic [15:0]      rd_word;
  logic [CNT_W-1:0] lock_cnt;
  logic [LANES-1:0] sel_n;
  logic             rd_mode, wr_go;

  assign sel_n   = {ub_n, lb_n};
  assign rd_word = mem[addr];
  assign dout    = rd_word;
  assign rd_mode = !ce_n && we_n && !oe_n;
  assign dq_oe   = {LANES{rd_mode}} & ~sel_n;
  assign wr_go   = !vdd_low && (lock_cnt == '0) && !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lock_cnt <= CNT_W'(LOCK_CYCLES);
    else if (vdd_low)          lock_cnt <= CNT_W'(LOCK_CYCLES);
    else if (lock_cnt != '0)   lock_cnt <= lock_cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_go)
      for (int i = 0; i < LANES; i++)
        if (!sel_n[i]) mem[addr][i*8 +: 8] <= din[i*8 +: 8];
  end

  a_r2_deselect_float: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> dq_oe == 2'b00);
  a_r6_no_write_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> mem[$past(addr)] == $past(rd_word));
  a_r5_lower_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n && lb_n) |=> mem[$past(addr)][7:0] == $past(rd_word[7:0]));
  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n && ub_n) |=> mem[$past(addr)][15:8] == $past(rd_word[15:8]));
  a_r7_inhibit_array: assert property (@(posedge clk) disable iff (!rst_n)
    vdd_low |=> mem[$past(addr)] == $past(rd_word));
  a_r9_relock: assert property (@(posedge clk) disable iff (!rst_n)
    vdd_low |=> lock_cnt == CNT_W'(LOCK_CYCLES));
  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!vdd_low && lock_cnt != '0) |=> lock_cnt == $past(lock_cnt) - CNT_W'(1));
endmodule

// File: tb/sim_byte_lane_mem.sv
module sim_byte_lane_mem;
  localparam int CLK_P  = 10;
  localparam int AW     = 6;
  localparam int LOCK   = 20;
  localparam int TOP    = (1 << AW) - 1;

  logic clk = 0, rst_n = 0, vdd_low = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1, lb_n = 1, ub_n = 1;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0, dout;
  logic [1:0] dq_oe;
  int total = 0, fails = 0;

  byte_lane_mem #(.ADDR_W(AW), .LOCK_CYCLES(LOCK)) u0 (
    .clk(clk), .rst_n(rst_n), .vdd_low(vdd_low), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .din(din),
    .dout(dout), .dq_oe(dq_oe));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1; we_n = 1; oe_n = 1; lb_n = 1; ub_n = 1;
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic l, input logic u);
    @(negedge clk);
    addr = a[AW-1:0]; din = d; ce_n = 0; we_n = 0; oe_n = 0; lb_n = l; ub_n = u;
    #1 chk(dq_oe == 2'b00, "R5", dq_oe, 0);
    @(negedge clk); idle();
  endtask

  task automatic rd(input int a, input logic l, input logic u, input logic o,
                    input logic [15:0] exp, input logic [1:0] exp_oe, input string req);
    @(negedge clk);
    addr = a[AW-1:0]; ce_n = 0; we_n = 1; oe_n = o; lb_n = l; ub_n = u;
    #1;
    chk(dq_oe == exp_oe, req, dq_oe, exp_oe);
    if (exp_oe[0]) chk(dout[7:0] == exp[7:0], req, dout[7:0], exp[7:0]);
    if (exp_oe[1]) chk(dout[15:8] == exp[15:8], req, dout[15:8], exp[15:8]);
  endtask

  task automatic hold_blocked(input int a, input logic [15:0] d, input logic [15:0] old,
                              input string req);
    addr = a[AW-1:0]; din = d; ce_n = 0; we_n = 0; oe_n = 1; lb_n = 0; ub_n = 0;
    repeat (LOCK) @(negedge clk);
    we_n = 1; oe_n = 0;
    #1 chk(dout == old, req, dout, old);
    we_n = 0; oe_n = 1;
    @(negedge clk);
    we_n = 1; oe_n = 0;
    #1 chk(dout == d, req, dout, d);
    idle();
  endtask

  task automatic t_reset();
    ce_n = 0; we_n = 1; oe_n = 0; lb_n = 0; ub_n = 0; #1; ce_n = 1;
    #1 chk(dq_oe == 2'b00, "R2", dq_oe, 0);
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (LOCK + 2) @(negedge clk);
  endtask

  task automatic t_word();
    wr(5, 16'h1234, 0, 0);
    rd(5, 0, 0, 0, 16'h1234, 2'b11, "R1");
    rd(5, 0, 1, 0, 16'h1234, 2'b01, "R3");
    rd(5, 1, 0, 0, 16'h1234, 2'b10, "R3");
    wr(0, 16'hBEEF, 0, 0);
    wr(TOP, 16'hC0DE, 0, 0);
    rd(0, 0, 0, 0, 16'hBEEF, 2'b11, "R1");
    rd(TOP, 0, 0, 0, 16'hC0DE, 2'b11, "R1");
  endtask

  task automatic t_float();
    rd(5, 0, 0, 1, 16'h1234, 2'b00, "R4");
    rd(5, 1, 1, 0, 16'h1234, 2'b00, "R4");
    @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 0; lb_n = 0; ub_n = 0;
    #1 chk(dq_oe == 2'b00, "R2", dq_oe, 0);
    idle();
  endtask

  task automatic t_bytes();
    wr(5, 16'hABCD, 0, 1);
    rd(5, 0, 0, 0, 16'h12CD, 2'b11, "R5");
    wr(5, 16'h5600, 1, 0);
    rd(5, 0, 0, 0, 16'h56CD, 2'b11, "R5");
    wr(5, 16'h7777, 1, 1);
    rd(5, 0, 0, 0, 16'h56CD, 2'b11, "R5");
  endtask

  task automatic t_ce();
    @(negedge clk);
    addr = 5; din = 16'hFFFF; ce_n = 1; we_n = 0; oe_n = 0; lb_n = 0; ub_n = 0;
    #1 chk(dq_oe == 2'b00, "R2", dq_oe, 0);
    @(negedge clk); idle();
    rd(5, 0, 0, 0, 16'h56CD, 2'b11, "R6");
  endtask

  task automatic t_vdd();
    wr(9, 16'h0F0F, 0, 0);
    @(negedge clk);
    vdd_low = 1; addr = 9; din = 16'hAAAA; ce_n = 0; we_n = 0; lb_n = 0; ub_n = 0;
    @(negedge clk);
    vdd_low = 0; we_n = 1; oe_n = 0;
    #1 chk(dout == 16'h0F0F, "R7", dout, 16'h0F0F);
    hold_blocked(9, 16'hAAAA, 16'h0F0F, "R9");
  endtask

  task automatic t_persist();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(5, 0, 0, 0, 16'h56CD, 2'b11, "R10");
    rd(TOP, 0, 0, 0, 16'hC0DE, 2'b11, "R10");
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    hold_blocked(0, 16'h4242, 16'hBEEF, "R8");
  endtask

  initial begin
    t_reset();
    t_word();
    t_float();
    t_bytes();
    t_ce();
    t_vdd();
    t_persist();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule